// File: doc/BRIEF.md
# Entropy-Coded Stream Packer with Escape, Trailer and Alignment Padding

This block sits right after the variable-length coder of an image compressor. Each cycle that input is accepted, it takes one code, given as a value and a bit count. It joins the codes MSB-first into bytes. When a byte of the compressed data comes out as 0xFF, a 0x00 byte is forced in straight after it, so that the marker space of the stream stays free. Bytes are paired into 16-bit output words. The first byte of each pair sits in bits 15:8.

The final code of a frame carries an end flag and comes with the frame timestamp. After that code the block closes the frame. It completes the last partial byte with 1 bits and escapes that byte if it became 0xFF. It then writes zero bytes until the frame reaches byte offset ALIGN-8-TAIL_GAP of a chunk. It then writes an 8-byte trailer holding the timestamp and the escaped byte count, and finally TAIL_GAP zero bytes. The frame therefore always ends on an ALIGN-byte boundary, and the trailer always sits at the same distance from that boundary. The output uses a valid/ready handshake. The input is held off whenever the block is emitting bytes that do not come from new codes.

Top module: `code_packer`

## Requirements
- R1: After reset, out_valid and out_last are 0 and in_ready is 1.
- R2: Codes of 1 to 27 bits are joined MSB-first into bytes in arrival order. The earlier byte of each pair is placed in out_data[15:8] and the later one in out_data[7:0].
- R3: Every 0xFF byte of compressed data is followed at once by one inserted 0x00 byte.
- R4: At frame end, a partial final byte is completed with 1 bits in its low positions. If that completed byte is 0xFF, it is escaped as in R3.
- R5: The trailer length field holds the number of compressed bytes, counted after escaping and including the completed final byte. It excludes padding and trailer, is 24 bits wide and is written MSB first.
- R6: The trailer is 8 bytes in this order: timestamp bits 31:24, 23:16, 15:8, 7:0, then 0x00, then the length bits 23:16, 15:8, 7:0. The timestamp is the value of in_ts at the cycle the code flagged by in_last is accepted.
- R7: Zero bytes fill the gap from the end of the compressed data to chunk offset 20. The trailer then starts at offset 20, and 4 zero bytes follow it. The frame size is a whole number of 32-byte chunks (defaults ALIGN=32, TAIL_GAP=4).
- R8: out_last is 1 on the final word of each frame and 0 on all other words.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold and no word is lost.
- R10: From the cycle after the code flagged by in_last is accepted, in_ready stays 0 until the frame's trailer and padding have been handed to the output stage.
- R11: A frame holding only an end-flagged code of length 0 produces exactly 32 bytes: 20 zeros, the trailer with length 0, then 4 zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | The offered code is taken at this edge |
| in_code | input | 27 | Code value, right-aligned |
| in_len | input | 5 | Number of code bits, 0 to 27 |
| in_last | input | 1 | This code ends the frame |
| in_ts | input | 32 | Frame timestamp, sampled with the last code |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 16 | Two stream bytes, the earlier in the high half |
| out_last | output | 1 | Final word of the frame |

## Verification
The bench sweeps every code length from 1 to 27 with mixed bit patterns, which separates packing order errors from length masking errors. It runs runs of all-ones codes that make back-to-back 0xFF bytes, which shows whether escapes are inserted, counted and placed next to the right byte. Frames ending 0 to 7 bits past a byte edge, including one whose completion byte turns into 0xFF, test the completion rule. Frames whose data ends exactly at offset 20, one byte past it, and past several chunks test the padding arithmetic and a length field above 255, first with out_ready held high and then with out_ready stalled at random.

// File: rtl/cp_pkg.sv
package cp_pkg;

  localparam int TRAIL_BYTES = 8;
  localparam int TS_W        = 32;
  localparam int BLEN_W      = 24;

  typedef enum logic [2:0] {
    ST_DATA,
    ST_ESC,
    ST_PAD,
    ST_TRAIL,
    ST_GAP
  } seq_state_t;

  // Trailer byte at index idx: timestamp MSB first, a zero byte, length MSB first.
  function automatic logic [7:0] trailer_byte(input logic [2:0] idx,
                                              input logic [TS_W-1:0] ts,
                                              input logic [BLEN_W-1:0] blen);
    logic [7:0] b;
    case (idx)
      3'd0:    b = ts[31:24];
      3'd1:    b = ts[23:16];
      3'd2:    b = ts[15:8];
      3'd3:    b = ts[7:0];
      3'd4:    b = 8'h00;
      3'd5:    b = blen[23:16];
      3'd6:    b = blen[15:8];
      default: b = blen[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cp_bit_accum.sv
module cp_bit_accum #(
  parameter int CODE_W = 27,
  parameter int LEN_W  = $clog2(CODE_W + 1),
  localparam int ACC_W = CODE_W + 7,
  localparam int CNT_W = $clog2(ACC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_en,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_last,
  output logic              in_ready,
  output logic              last_fire,
  input  logic              take,
  input  logic              frame_clr,
  output logic              has_byte,
  output logic [7:0]        byte_out,
  output logic              drained,
  output logic [CNT_W-1:0]  fill_cnt
);

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             pend_last;
  logic             full_byte;
  logic             accept;

  function automatic logic [CODE_W-1:0] mask_code(input logic [CODE_W-1:0] c,
                                                  input logic [LEN_W-1:0] n);
    return c & ~({CODE_W{1'b1}} << n);
  endfunction

  // Oldest 8 bits when at least 8 are held.
  function automatic logic [7:0] head_byte(input logic [ACC_W-1:0] a,
                                           input logic [CNT_W-1:0] c);
    logic [ACC_W-1:0] s;
    s = a >> (c - CNT_W'(8));
    return s[7:0];
  endfunction

  // Remaining 1..7 bits moved to the top, low positions filled with ones.
  function automatic logic [7:0] tail_byte(input logic [ACC_W-1:0] a,
                                           input logic [CNT_W-1:0] c);
    logic [ACC_W-1:0] s;
    logic [2:0]       r;
    r = c[2:0];
    s = a << (4'd8 - {1'b0, r});
    return s[7:0] | (8'hFF >> r);
  endfunction

  assign full_byte = (cnt >= CNT_W'(8));
  assign in_ready  = accept_en && !pend_last && !full_byte;
  assign accept    = in_ready && in_valid;
  assign last_fire = accept && in_last;
  assign has_byte  = full_byte || (pend_last && cnt != '0);
  assign drained   = pend_last && cnt == '0;
  assign byte_out  = full_byte ? head_byte(acc, cnt) : tail_byte(acc, cnt);
  assign fill_cnt  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      cnt       <= '0;
      pend_last <= 1'b0;
    end else begin
      if (accept) begin
        acc       <= (acc << in_len) | {{(ACC_W-CODE_W){1'b0}}, mask_code(in_code, in_len)};
        cnt       <= cnt + CNT_W'(in_len);
        pend_last <= in_last;
      end else if (take) begin
        cnt <= full_byte ? cnt - CNT_W'(8) : '0;
      end
      if (frame_clr) pend_last <= 1'b0;
    end
  end

endmodule

// File: rtl/cp_word_pack.sv
module cp_word_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  input  logic        byte_end,
  output logic        byte_ok,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data,
  output logic        out_last
);

  logic [7:0] hi_q;
  logic       have_hi;

  // A low byte needs the output slot free or leaving this cycle.
  assign byte_ok = !have_hi || !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      have_hi   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (byte_vld && byte_ok) begin
        if (!have_hi) begin
          hi_q    <= byte_dat;
          have_hi <= 1'b1;
        end else begin
          out_data  <= {hi_q, byte_dat};
          out_last  <= byte_end;
          out_valid <= 1'b1;
          have_hi   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/code_packer.sv
module code_packer #(
  parameter int CODE_W   = 27,
  parameter int LEN_W    = $clog2(CODE_W + 1),
  parameter int ALIGN    = 32,
  parameter int TAIL_GAP = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [CODE_W-1:0]        in_code,
  input  logic [LEN_W-1:0]         in_len,
  input  logic                     in_last,
  input  logic [cp_pkg::TS_W-1:0]  in_ts,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [15:0]              out_data,
  output logic                     out_last
);
  import cp_pkg::*;

  localparam int ACC_W       = CODE_W + 7;
  localparam int CNT_W       = $clog2(ACC_W + 1);
  localparam int POS_W       = $clog2(ALIGN);
  localparam int TRAIL_START = ALIGN - TRAIL_BYTES - TAIL_GAP;

  seq_state_t        state, nxt;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  rel;
  logic [BLEN_W-1:0] blen;
  logic [TS_W-1:0]   ts_q;

  // Named internal events, also observed by the checker.
  logic              byte_vld, byte_ok, byte_end, byte_fire, byte_from_acc;
  logic [7:0]        byte_dat;
  logic              take, frame_clr, last_fire, has_byte, drained, is_final;
  logic [7:0]        acc_byte;
  logic [CNT_W-1:0]  fill_cnt;

  cp_bit_accum #(.CODE_W(CODE_W), .LEN_W(LEN_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .accept_en(state == ST_DATA),
    .in_valid(in_valid), .in_code(in_code), .in_len(in_len), .in_last(in_last),
    .in_ready(in_ready), .last_fire(last_fire), .take(take), .frame_clr(frame_clr),
    .has_byte(has_byte), .byte_out(acc_byte), .drained(drained), .fill_cnt(fill_cnt)
  );

  cp_word_pack i_wpack (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_end(byte_end), .byte_ok(byte_ok), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  assign rel       = pos - POS_W'(TRAIL_START);
  assign is_final  = (pos == POS_W'(ALIGN - 1));
  assign byte_fire = byte_vld && byte_ok;
  assign frame_clr = byte_fire && byte_end;

  always_comb begin
    nxt           = state;
    byte_vld      = 1'b0;
    byte_dat      = 8'h00;
    byte_end      = 1'b0;
    byte_from_acc = 1'b0;
    take          = 1'b0;
    case (state)
      ST_DATA: begin
        if (has_byte) begin
          byte_vld      = 1'b1;
          byte_dat      = acc_byte;
          byte_from_acc = 1'b1;
          if (byte_ok) begin
            take = 1'b1;
            if (acc_byte == 8'hFF) nxt = ST_ESC;
          end
        end else if (drained) begin
          nxt = ST_PAD;
        end
      end
      ST_ESC: begin
        byte_vld = 1'b1;
        if (byte_ok) nxt = ST_DATA;
      end
      ST_PAD: begin
        if (pos == POS_W'(TRAIL_START)) nxt = ST_TRAIL;
        else                            byte_vld = 1'b1;
      end
      ST_TRAIL: begin
        byte_vld = 1'b1;
        byte_dat = trailer_byte(rel[2:0], ts_q, blen);
        byte_end = is_final;
        if (byte_ok) begin
          if (is_final)              nxt = ST_DATA;
          else if (rel[2:0] == 3'd7) nxt = ST_GAP;
        end
      end
      ST_GAP: begin
        byte_vld = 1'b1;
        byte_end = is_final;
        if (byte_ok && is_final) nxt = ST_DATA;
      end
      default: nxt = ST_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_DATA;
      pos   <= '0;
      blen  <= '0;
      ts_q  <= '0;
    end else begin
      state <= nxt;
      if (byte_fire) pos <= pos + 1'b1;
      if (last_fire) ts_q <= in_ts;
      if (frame_clr) blen <= '0;
      else if (byte_fire && (state == ST_DATA || state == ST_ESC)) blen <= blen + 1'b1;
    end
  end

endmodule

// File: rtl/cp_checker.sv
module cp_checker #(
  parameter int CNT_W    = 6,
  parameter int FILL_MAX = 34,
  parameter int ALIGN    = 32,
  localparam int WORDS   = ALIGN / 2,
  localparam int WC_W    = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic             out_last,
  input logic             byte_fire,
  input logic [7:0]       byte_dat,
  input logic             byte_from_acc,
  input logic [CNT_W-1:0] fill_cnt
);

  logic            prev_ff;
  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ff <= 1'b0;
      wcnt    <= '0;
    end else begin
      if (byte_fire) prev_ff <= byte_from_acc && byte_dat == 8'hFF;
      if (out_valid && out_ready) wcnt <= wcnt + 1'b1;
    end
  end

  AST_ESC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire && prev_ff |-> byte_dat == 8'h00 && !byte_from_acc);  // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));  // R9

  AST_LAST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> wcnt == WC_W'(WORDS - 1));  // R7

  AST_INPUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);  // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(FILL_MAX));  // R2

endmodule

bind code_packer cp_checker #(.CNT_W(CNT_W), .FILL_MAX(ACC_W), .ALIGN(ALIGN)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .byte_fire(byte_fire), .byte_dat(byte_dat), .byte_from_acc(byte_from_acc),
  .fill_cnt(fill_cnt)
);

// File: tb/test_code_packer.sv
`timescale 1ns/1ps
module test_code_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [26:0] in_code = '0;
  logic [4:0]  in_len = '0;
  logic        in_last = 1'b0;
  logic [31:0] in_ts = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_last;

  int    ntests = 0;
  int    nfail = 0;
  bit    rnd_ready = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R2";

  int    exp_b[$];
  bit    exp_e[$];
  string exp_t[$];
  int    fc[$];
  int    fl[$];

  always #2 clk = ~clk;

  code_packer i_code_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_len(in_len), .in_last(in_last), .in_ts(in_ts),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push_exp(input int b, input string t);
    exp_b.push_back(b);
    exp_e.push_back(1'b0);
    exp_t.push_back(t);
  endtask

  // Expected byte stream of one frame, built from the requirements.
  task automatic model_frame(input int ts);
    bit bq[$];
    int n;
    int v;
    for (int i = 0; i < fc.size(); i++)
      for (int b = fl[i] - 1; b >= 0; b--) bq.push_back(bit'((fc[i] >> b) & 1));
    n = 0;
    while (bq.size() >= 8) begin
      v = 0;
      for (int k = 0; k < 8; k++) v = (v << 1) | int'(bq.pop_front());
      push_exp(v, cur_tag); n++;
      if (v == 255) begin push_exp(0, "R3"); n++; end
    end
    if (bq.size() > 0) begin
      int r;
      r = bq.size();
      v = 0;
      for (int k = 0; k < 8; k++) v = (v << 1) | ((k < r) ? int'(bq.pop_front()) : 1);
      push_exp(v, "R4"); n++;
      if (v == 255) begin push_exp(0, "R4"); n++; end
    end
    while ((exp_b.size() % 32) != 20) push_exp(0, "R7");
    for (int k = 3; k >= 0; k--) push_exp((ts >> (8 * k)) & 255, "R6");
    push_exp(0, "R6");
    for (int k = 2; k >= 0; k--) push_exp((n >> (8 * k)) & 255, "R5");
    for (int k = 0; k < 4; k++) push_exp(0, "R7");
    exp_e[exp_e.size() - 1] = 1'b1;
  endtask

  task automatic send(input int code, input int len, input bit last);
    in_code  = 27'(code);
    in_len   = 5'(len);
    in_last  = last;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (last) check(in_ready == 1'b0, "R10 in_ready after last", int'(in_ready), 0);
  endtask

  task automatic run_frame(input int ts, input string tag);
    cur_tag = tag;
    in_ts   = ts;
    model_frame(ts);
    for (int i = 0; i < fc.size(); i++) send(fc[i], fl[i], i == fc.size() - 1);
    while (exp_b.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    fc.delete();
    fl.delete();
  endtask

  // Output collector and stall monitor.
  logic [15:0] held_d;
  bit          held_l;
  bit          stalled = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        check(out_valid && out_data == held_d && out_last == held_l,
              "R9 held word", int'(out_data), int'(held_d));
      end
      out_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
      stalled = out_valid && !out_ready;
      held_d  = out_data;
      held_l  = out_last;
      if (out_valid && out_ready) begin
        if (exp_b.size() < 2) begin
          check(1'b0, "R8 unexpected word", int'(out_data), 0);
        end else begin
          int    hb;
          int    lb;
          bit    le;
          string ht;
          string lt;
          hb = exp_b.pop_front(); void'(exp_e.pop_front()); ht = exp_t.pop_front();
          lb = exp_b.pop_front(); le = exp_e.pop_front();   lt = exp_t.pop_front();
          check(int'(out_data[15:8]) == hb, {ht, " high byte"}, int'(out_data[15:8]), hb);
          check(int'(out_data[7:0]) == lb, {lt, " low byte"}, int'(out_data[7:0]), lb);
          check(out_last == le, "R8 last flag", int'(out_last), int'(le));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++; ntests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R11: empty frame
    fc.push_back(0); fl.push_back(0);
    run_frame(32'h1234_5678, "R11");

    // R2: all lengths with mixed patterns
    for (int l = 1; l <= 27; l++) begin fc.push_back(32'h0529_A5C3 ^ (l * 977)); fl.push_back(l); end
    run_frame(32'hCAFE_0001, "R2");
    for (int l = 27; l >= 1; l--) begin fc.push_back(l); fl.push_back(l); end
    run_frame(32'h0000_00FF, "R2");

    // R3: runs of ones
    for (int i = 0; i < 5; i++) begin fc.push_back(32'h07FF_FFFF); fl.push_back(27); end
    fc.push_back(3); fl.push_back(8);
    run_frame(32'hFFFF_FFFF, "R3");

    // R4: completion byte, plain and turning into 0xFF, for 1..7 leftover bits
    fc.push_back(15); fl.push_back(4);
    run_frame(32'h0000_0004, "R4");
    for (int r = 1; r <= 7; r++) begin
      fc.push_back(8'h3C); fl.push_back(8);
      fc.push_back(2); fl.push_back(r);
      run_frame(32'h0400_0000 + r, "R4");
    end

    // R7: data ends exactly at offset 20, then one past it
    for (int i = 0; i < 20; i++) begin fc.push_back(1); fl.push_back(8); end
    run_frame(32'h2020_2020, "R7");
    for (int i = 0; i < 21; i++) begin fc.push_back(i + 2); fl.push_back(8); end
    run_frame(32'h2121_2121, "R7");

    // R5 and R9: long frames under random backpressure
    rnd_ready = 1'b1;
    for (int i = 0; i < 420; i++) begin fc.push_back(int'($urandom & 32'hFFFF)); fl.push_back(16); end
    run_frame(32'h5555_AAAA, "R5");
    for (int i = 0; i < 300; i++) begin
      int l;
      l = 1 + int'($urandom % 27);
      fc.push_back(int'($urandom) & ((1 << l) - 1)); fl.push_back(l);
    end
    run_frame(32'h9999_0000, "R9");
    rnd_ready = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule